// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent down-counters behind one word-addressed register window. Software programs a reload value and a control word for each counter. An enabled counter then decrements once per clock. When it hits zero it raises a sticky expiry flag. In periodic mode it reloads and keeps running. In one-shot mode it parks at zero.

Each counter drives its own level interrupt. That interrupt is the expiry flag gated by an interrupt-enable bit. A second reload register lets software change the period for the next cycle without disturbing the count in progress. Writing the control word or the reload value while the counter is enabled restarts the count at once.

The bus is a single-cycle write strobe with a word index and 32-bit data. Read data is a combinational function of the index and the register state, and every access is a full word.

Top module: `dual_interval_timer`

## Requirements
- R1: Word index 0..5 maps the first counter's registers: 0 live count, 1 reload value, 2 deferred reload, 3 control, 4 raw flag, 5 masked flag. Index 6..11 maps the same layout for the second counter. Index 12..15 reads zero, and writes there change nothing.
- R2: While a counter is running and its count is non-zero, the count drops by one on every clock. Reading index 0 returns the count as it stands.
- R3: A control write stores bits [2:0], which are bit 0 enable, bit 1 one-shot (periodic when 0) and bit 2 interrupt enable. Upper bits read as zero. With enable set, the count restarts from the reload value on the next clock. With enable clear, the count freezes.
- R4: A reload-value write stores the value. If control enable is set, the count restarts from that value on the next clock. Otherwise the count is untouched.
- R5: A deferred-reload write updates both the deferred-reload and reload-value registers without altering the running count. The new value takes effect at the next reload.
- R6: A running counter at zero expires: it sets raw flag bit 0. In periodic mode it reloads from the reload value, giving a period of N+1 clocks for a reload value of N. In one-shot mode it stops at zero.
- R7: Writing 1 to raw flag bit 0 clears it, and writing 0 leaves it. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: The masked flag reads raw bit 0 AND interrupt enable. The interrupt output equals the same AND.
- R9: Writes to the live count and masked flag indices are ignored.
- R10: After reset, every register and count reads zero, both counters are stopped, and both interrupts are low.
- R11: Activity on one counter never changes the other counter's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 2 | Level interrupt, one per counter |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an expiry and a software clear of the raw flag. The bench provokes it by writing the clear bit on every cycle across a reload boundary, and the expiry must win. The second pair is an expiry and a restart, or a deferred-reload write. These are provoked by long random write streams with short reload values. The reference model judges each collision on every clock through the read data and both interrupts.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int REGS_PER_CH = 6;
    localparam int CTRL_W      = 3;
    localparam int CTRL_EN     = 0;
    localparam int CTRL_ONE    = 1;
    localparam int CTRL_IEN    = 2;

    typedef enum logic [2:0] {
        IDX_COUNT  = 3'd0,
        IDX_RELOAD = 3'd1,
        IDX_DEFER  = 3'd2,
        IDX_CTRL   = 3'd3,
        IDX_RAW    = 3'd4,
        IDX_MASKED = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
    import dit_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_idx_e          idx
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        ch_hit = '0;
        idx    = IDX_COUNT;
        offset = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if ((int'(addr) >= c * REGS_PER_CH) && (int'(addr) < (c + 1) * REGS_PER_CH)) begin
                ch_hit[c] = 1'b1;
                offset    = addr - ADDR_W'(c * REGS_PER_CH);
                idx       = reg_idx_e'(offset[2:0]);
            end
        end
    end
endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] defer;
        logic [CTRL_W-1:0] ctrl;
        logic              raw;
        logic              run;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      expire;
    logic      clr_raw;
    logic      restart_wr;

    always_comb begin
        st_d       = st_q;
        expire     = st_q.run && (st_q.count == '0);
        clr_raw    = wr_sel && (idx == IDX_RAW) && wdata[0];
        restart_wr = wr_sel && ((idx == IDX_CTRL) || (idx == IDX_RELOAD));

        if (st_q.run) begin
            if (expire) begin
                if (st_q.ctrl[CTRL_ONE]) st_d.run = 1'b0;
                else                     st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        st_d.raw = expire | (st_q.raw & ~clr_raw);

        if (wr_sel) begin
            unique case (idx)
                IDX_RELOAD: begin
                    st_d.reload = wdata;
                    if (st_q.ctrl[CTRL_EN]) begin
                        st_d.count = wdata;
                        st_d.run   = 1'b1;
                    end
                end
                IDX_DEFER: begin
                    st_d.defer  = wdata;
                    st_d.reload = wdata;
                end
                IDX_CTRL: begin
                    st_d.ctrl = wdata[CTRL_W-1:0];
                    if (wdata[CTRL_EN]) begin
                        st_d.count = st_q.reload;
                        st_d.run   = 1'b1;
                    end else begin
                        st_d.count = st_q.count;
                        st_d.run   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (idx)
            IDX_COUNT:  rd_data = st_q.count;
            IDX_RELOAD: rd_data = st_q.reload;
            IDX_DEFER:  rd_data = st_q.defer;
            IDX_CTRL:   rd_data = DATA_W'(st_q.ctrl);
            IDX_RAW:    rd_data = DATA_W'(st_q.raw);
            IDX_MASKED: rd_data = DATA_W'(st_q.raw & st_q.ctrl[CTRL_IEN]);
            default:    rd_data = '0;
        endcase
    end

    assign irq = st_q.raw & st_q.ctrl[CTRL_IEN];

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.count != '0 && !restart_wr) |=> (st_q.count == $past(st_q.count) - 1'b1));

    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && idx == IDX_CTRL && !wdata[CTRL_EN]) |=> (st_q.count == $past(st_q.count) && !st_q.run));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && idx == IDX_RELOAD && st_q.ctrl[CTRL_EN]) |=> (st_q.count == $past(wdata) && st_q.run));

    assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.ctrl[CTRL_ONE] && !restart_wr) |=> (st_q.count == $past(st_q.reload) && st_q.raw));

    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.ctrl[CTRL_ONE] && !restart_wr) |=> (!st_q.run && st_q.count == '0));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_raw && !expire) |=> !st_q.raw);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.raw);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WINDOW = NUM_CH * REGS_PER_CH;

    initial begin
        assert ((1 << ADDR_W) >= WINDOW) else $error("address width too small for window");
    end

    logic [NUM_CH-1:0] ch_hit;
    reg_idx_e          idx;
    logic [DATA_W-1:0] ch_rd [NUM_CH];

    dit_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .addr   (addr),
        .ch_hit (ch_hit),
        .idx    (idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dit_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_en && ch_hit[c]),
            .idx     (idx),
            .wdata   (wdata),
            .rd_data (ch_rd[c]),
            .irq     (irq[c])
        );

        assert_masked_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[c] && idx == IDX_MASKED) |-> (rdata == DATA_W'(irq[c])));
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) rdata = rdata | ch_rd[c];
        end
    end

    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= WINDOW) |-> (rdata == '0));
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_cnt [2];
    logic [31:0] m_rel [2];
    logic [31:0] m_def [2];
    logic [2:0]  m_ctl [2];
    bit          m_raw [2];
    bit          m_run [2];

    always #2 clk = ~clk;

    dual_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic void model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_rel[i] = 0; m_def[i] = 0;
            m_ctl[i] = 0; m_raw[i] = 0; m_run[i] = 0;
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        int ch;
        int r;
        if (a >= 12) return 32'h0;
        ch = (a >= 6) ? 1 : 0;
        r  = int'(a) - ch * 6;
        case (r)
            0: return m_cnt[ch];
            1: return m_rel[ch];
            2: return m_def[ch];
            3: return {29'h0, m_ctl[ch]};
            4: return {31'h0, m_raw[ch]};
            default: return {31'h0, m_raw[ch] & m_ctl[ch][2]};
        endcase
    endfunction

    function automatic void model_clock(input bit we, input logic [3:0] a, input logic [31:0] d);
        int wch;
        int r;
        wch = (a >= 12) ? -1 : ((a >= 6) ? 1 : 0);
        r   = (wch < 0) ? -1 : int'(a) - wch * 6;
        for (int i = 0; i < 2; i++) begin
            bit hit;
            bit exp_now;
            hit = we && (wch == i);
            exp_now = m_run[i] && (m_cnt[i] == 0);
            // timer progress
            if (m_run[i]) begin
                if (exp_now) begin
                    if (m_ctl[i][1]) m_run[i] = 0;
                    else             m_cnt[i] = m_rel[i];
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (hit && r == 4 && d[0]) m_raw[i] = 0;
            if (exp_now) m_raw[i] = 1;
            if (hit) begin
                if (r == 1) begin
                    m_rel[i] = d;
                    if (m_ctl[i][0]) begin m_cnt[i] = d; m_run[i] = 1; end
                end else if (r == 2) begin
                    m_def[i] = d; m_rel[i] = d;
                end else if (r == 3) begin
                    m_ctl[i] = d[2:0];
                    if (d[0]) begin m_cnt[i] = m_rel[i]; m_run[i] = 1; end
                    else begin
                        m_run[i] = 0;
                        if (exp_now && !m_ctl[i][1]) m_cnt[i] = m_cnt[i];
                    end
                end
            end
        end
    endfunction

    // control write with enable clear must freeze the pre-edge count
    logic [31:0] pre_cnt [2];

    task automatic check(input string req);
        logic [31:0] erd;
        logic [1:0]  eirq;
        erd  = model_read(addr);
        eirq = {m_raw[1] & m_ctl[1][2], m_raw[0] & m_ctl[0][2]};
        compared++;
        if (rdata !== erd || irq !== eirq) begin
            mismatched++;
            $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, addr, rdata, irq, erd, eirq);
        end
    endtask

    task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d;
        #1;
        check(req);
        @(posedge clk);
        pre_cnt[0] = m_cnt[0];
        pre_cnt[1] = m_cnt[1];
        model_clock(we, a, d);
        // a disabling control write keeps the count held before the edge
        for (int i = 0; i < 2; i++)
            if (we && a == 4'(3 + 6 * i) && !d[0]) m_cnt[i] = pre_cnt[i];
    endtask

    task automatic idle(input int n, input logic [3:0] a, input string req);
        for (int k = 0; k < n; k++) step(0, a, 32'h0, req);
    endtask

    initial begin
        model_reset();
        repeat (3) begin
            @(negedge clk);
            addr = addr + 4'd1;
            #1;
            check("R10");
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) step(0, 4'(a), 32'h0, "R10");

        // R1 map and R9 ignored writes, channel 0 disabled
        step(1, 4'd1, 32'd7, "R1");
        step(0, 4'd1, 32'h0, "R1");
        step(1, 4'd7, 32'hABCD, "R1");
        step(0, 4'd7, 32'h0, "R1");
        for (int a = 12; a < 16; a++) step(1, 4'(a), 32'hFFFF_FFFF, "R1");
        for (int a = 0; a < 16; a++) step(0, 4'(a), 32'h0, "R1");
        step(1, 4'd0, 32'h55, "R9");
        step(1, 4'd5, 32'h1, "R9");
        step(0, 4'd0, 32'h0, "R9");

        // R3 upper bits dropped, periodic with interrupt (R2, R6, R8)
        step(1, 4'd3, 32'hFFFF_FFF5, "R3");
        idle(20, 4'd0, "R2");
        step(0, 4'd4, 32'h0, "R6");
        step(0, 4'd5, 32'h0, "R8");
        step(0, 4'd3, 32'h0, "R3");

        // R7 write 0 no effect, write 1 clears
        step(1, 4'd4, 32'h0, "R7");
        step(0, 4'd4, 32'h0, "R7");
        step(1, 4'd4, 32'h1, "R7");
        step(0, 4'd4, 32'h0, "R7");

        // R11 one-shot on channel 1 while channel 0 runs
        step(1, 4'd7, 32'd3, "R11");
        step(1, 4'd9, 32'h7, "R11");
        idle(10, 4'd6, "R6");
        step(0, 4'd10, 32'h0, "R11");
        step(1, 4'd10, 32'h1, "R11");
        idle(3, 4'd11, "R8");

        // R5 deferred reload while running
        step(1, 4'd2, 32'd2, "R5");
        idle(12, 4'd0, "R5");
        step(0, 4'd1, 32'h0, "R5");

        // R4 reload write while enabled restarts
        step(1, 4'd1, 32'd9, "R4");
        idle(4, 4'd0, "R4");
        step(1, 4'd1, 32'd5, "R4");
        idle(4, 4'd0, "R4");

        // R3 disable freezes, re-enable restarts from reload
        step(1, 4'd3, 32'h4, "R3");
        idle(4, 4'd0, "R3");
        step(1, 4'd1, 32'd4, "R4");
        idle(3, 4'd0, "R4");
        step(1, 4'd3, 32'h5, "R3");
        idle(3, 4'd0, "R3");

        // R7 clear on every cycle across expiries
        for (int k = 0; k < 14; k++) step(1, 4'd4, 32'h1, "R7");
        idle(2, 4'd4, "R7");

        // R11 mixed random traffic with short periods
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] ra;
            ra = 4'($urandom % 16);
            step(($urandom % 3) == 0, ra, 32'($urandom % 12), "R11");
        end
        idle(8, 4'd5, "R11");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule